// File: doc/BRIEF.md
# Root-Port Interrupt Status Controller

This block gathers the interrupt sources of one root port of a host bridge into a single 32-bit status word. It drives one combined interrupt line toward the parent interrupt controller. Sources 0 to 3 are the four legacy level-sensitive INTx lines, and status mirrors them directly. Every other source is an event pulse from logic around the port, such as link up (bit 12), link down (bit 14), bandwidth management (bit 11), error reporting (bits 4 to 7), completion timeout (bit 23), requester-to-stream map miss (bit 22), bad MSI data (bit 19) and tunnel error (bit 31). Each event latches into a sticky bit that software clears by writing a one to it.

Software reaches the block through a plain 32-bit register port with a write strobe, a read strobe and a byte address. The enable mask is read-only at its own offset. It changes only through two companion registers: writing ones to the first masks the selected sources, and writing ones to the second unmasks them. Concurrent software threads therefore never need a read-modify-write. The combined output is registered and rises when any source is both pending and unmasked.

Top module: `irq_port_ctrl`

## Requirements
- R1: After a cycle with `rst` high, status reads 0x00000000, the mask reads 0xFFFFFFFF and `irq_out` is 0.
- R2: Writing offset 0x108 sets every mask bit whose data bit is 1. Writing offset 0x10C clears every mask bit whose data bit is 1. Zero data bits leave the mask unchanged, and writes to the mask offset 0x104 have no effect.
- R3: Status bits 3..0 equal the `intx_lvl` value sampled at the previous clock edge, and a write to status does not clear them.
- R4: A clock edge with `evt_in[k]` high sets status bit k+4. The bit then stays set until a write to status offset 0x100 with data bit k+4 equal to 1.
- R5: If an event on a bit and a write-one-to-clear of the same bit arrive in the same cycle, the bit stays set.
- R6: `irq_out` equals the OR over all bits of (status AND NOT mask) as held in the previous cycle.
- R7: Writing 0xFFFFFFFF to 0x108 and then 0xFFFFFFFF to 0x100, with no events and INTx low, leaves status 0, mask all ones and `irq_out` 0.
- R8: With `bus_rd_en` high, `bus_rdata` returns status at 0x100 and the mask at 0x104 in the same cycle. It returns 0 at 0x108, at 0x10C, at any other address, and whenever `bus_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intx_lvl | input | 4 | Legacy level interrupt lines A..D |
| evt_in | input | 28 | Event pulses; bit k feeds status bit k+4 |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
Every cycle, the assertions check that INTx status follows the lines and that edge bits stay sticky unless a clear hits them. They also check that an event always wins over a clear, that mask-set writes take effect, and that the output tracks pending-and-unmasked state one cycle late. Only the bench scenarios can show the absolute values read back through the register port. These include the reset values, the mask offset ignoring writes, the software initialisation sequence and the zero reads of the write-only and unused offsets.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NUM_SRC = 32;
    localparam int NUM_LVL = 4;
    localparam int AW      = 12;

    localparam logic [AW-1:0] OFS_STAT = 12'h100;
    localparam logic [AW-1:0] OFS_MASK = 12'h104;
    localparam logic [AW-1:0] OFS_MSET = 12'h108;
    localparam logic [AW-1:0] OFS_MCLR = 12'h10C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_MASK,
        SEL_MSET,
        SEL_MCLR
    } reg_sel_t;

    typedef struct packed {
        logic               stat_w1c;
        logic               mask_set;
        logic               mask_clr;
        logic [NUM_SRC-1:0] data;
    } wr_op_t;

    function automatic reg_sel_t decode_addr(input logic [AW-1:0] a);
        case (a)
            OFS_STAT: decode_addr = SEL_STAT;
            OFS_MASK: decode_addr = SEL_MASK;
            OFS_MSET: decode_addr = SEL_MSET;
            OFS_MCLR: decode_addr = SEL_MCLR;
            default:  decode_addr = SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_agg_pkg::*;
(
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [AW-1:0]      addr,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] stat,
    input  logic [NUM_SRC-1:0] mask,
    output wr_op_t             op,
    output logic [NUM_SRC-1:0] rdata
);
    reg_sel_t sel;

    always_comb begin
        sel         = decode_addr(addr);
        op.stat_w1c = wr_en && (sel == SEL_STAT);
        op.mask_set = wr_en && (sel == SEL_MSET);
        op.mask_clr = wr_en && (sel == SEL_MCLR);
        op.data     = wdata;
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_STAT: rdata = stat;
                SEL_MASK: rdata = mask;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int N_LVL = NUM_LVL
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LVL-1:0]   lvl_in,
    input  logic [N_SRC-N_LVL-1:0] edge_in,
    input  logic               clr_en,
    input  logic [N_SRC-1:0]   clr_bits,
    output logic [N_SRC-1:0]   stat
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        if (i < N_LVL) begin : g_lvl
            always_ff @(posedge clk) begin
                if (rst) stat[i] <= 1'b0;
                else     stat[i] <= lvl_in[i];
            end
        end else begin : g_edge
            always_ff @(posedge clk) begin
                if (rst)                      stat[i] <= 1'b0;
                else if (edge_in[i-N_LVL])    stat[i] <= 1'b1;
                else if (clr_en && clr_bits[i]) stat[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [N_SRC-1:0] bits,
    output logic [N_SRC-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst)         mask <= '1;
        else if (set_en) mask <= mask | bits;
        else if (clr_en) mask <= mask & ~bits;
    end
endmodule

// File: rtl/irq_out_reduce.sv
module irq_out_reduce
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] stat,
    input  logic [N_SRC-1:0] mask,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(stat & ~mask);
    end
endmodule

// File: rtl/irq_port_ctrl.sv
module irq_port_ctrl
    import irq_agg_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_LVL-1:0]         intx_lvl,
    input  logic [NUM_SRC-NUM_LVL-1:0] evt_in,
    input  logic                       bus_wr_en,
    input  logic                       bus_rd_en,
    input  logic [AW-1:0]              bus_addr,
    input  logic [NUM_SRC-1:0]         bus_wdata,
    output logic [NUM_SRC-1:0]         bus_rdata,
    output logic                       irq_out
);
    wr_op_t             op;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] mask_q;

    irq_reg_decode u_dec (
        .wr_en (bus_wr_en),
        .rd_en (bus_rd_en),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .stat  (stat_q),
        .mask  (mask_q),
        .op    (op),
        .rdata (bus_rdata)
    );

    irq_status_bank #(.N_SRC(NUM_SRC), .N_LVL(NUM_LVL)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .lvl_in   (intx_lvl),
        .edge_in  (evt_in),
        .clr_en   (op.stat_w1c),
        .clr_bits (op.data),
        .stat     (stat_q)
    );

    irq_mask_bank #(.N_SRC(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_en (op.mask_set),
        .clr_en (op.mask_clr),
        .bits   (op.data),
        .mask   (mask_q)
    );

    irq_out_reduce #(.N_SRC(NUM_SRC)) u_out (
        .clk  (clk),
        .rst  (rst),
        .stat (stat_q),
        .mask (mask_q),
        .irq  (irq_out)
    );
endmodule

// File: rtl/irq_port_ctrl_chk.sv
module irq_port_ctrl_chk
    import irq_agg_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic [NUM_LVL-1:0]         intx_lvl,
    input logic [NUM_SRC-NUM_LVL-1:0] evt_in,
    input logic                       bus_wr_en,
    input logic [AW-1:0]              bus_addr,
    input logic [NUM_SRC-1:0]         bus_wdata,
    input logic [NUM_SRC-1:0]         stat_q,
    input logic [NUM_SRC-1:0]         mask_q,
    input logic                       irq_out
);
    logic clr_hit;
    assign clr_hit = bus_wr_en && (bus_addr == OFS_STAT);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (mask_q == '1) && (stat_q == '0) && !irq_out);

    p_mask_set_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == OFS_MSET)
        |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

    p_intx_follow_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat_q[NUM_LVL-1:0] == $past(intx_lvl)));

    p_irq_reduce_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(|(stat_q & ~mask_q))));

    for (genvar i = NUM_LVL; i < NUM_SRC; i++) begin : g_edge_chk
        p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
            (stat_q[i] && !(clr_hit && bus_wdata[i])) |=> stat_q[i]);
        p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
            evt_in[i-NUM_LVL] |=> stat_q[i]);
    end
endmodule

bind irq_port_ctrl irq_port_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .intx_lvl  (intx_lvl),
    .evt_in    (evt_in),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .irq_out   (irq_out)
);

// File: tb/irq_port_ctrl_tb.sv
module irq_port_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  intx_lvl = '0;
    logic [27:0] evt_in = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp_rd;
        logic        exp_irq;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_port_ctrl u_dut (
        .clk(clk), .rst(rst), .intx_lvl(intx_lvl), .evt_in(evt_in),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // monitor: compares pending expectations away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (bus_rdata !== it.exp_rd || irq_out !== it.exp_irq) begin
                    errors++;
                    $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                             it.tag, bus_rdata, irq_out, it.exp_rd, it.exp_irq);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp_rd,
                          input logic exp_irq, input string tag);
        item_t it;
        bus_rd_en = 1'b1; bus_addr = a;
        it.exp_rd = exp_rd; it.exp_irq = exp_irq; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        bus_rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [27:0] v);
        evt_in = v;
        @(posedge clk); #1;
        evt_in = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; rst = 1'b0;
        idle();

        // R1 reset values
        rd_chk(12'h100, 32'h0, 1'b0, "R1 status after reset");
        rd_chk(12'h104, 32'hFFFF_FFFF, 1'b0, "R1 mask after reset");

        // R4 link-up event (status bit 12 = evt_in[8]) latches while masked
        pulse(28'h1 << 8);
        idle(); idle();
        rd_chk(12'h100, 32'h0000_1000, 1'b0, "R4 link-up latched, R6 masked");

        // R2 unmask bit 12 via clear register; R6 output rises
        wr(12'h10C, 32'h0000_1000);
        idle();
        rd_chk(12'h104, 32'hFFFF_EFFF, 1'b1, "R2 clear-mask, R6 irq high");

        // R2 zero bits of set leave mask; writes to mask offset ignored
        wr(12'h108, 32'h0);
        wr(12'h104, 32'h0);
        idle();
        rd_chk(12'h104, 32'hFFFF_EFFF, 1'b1, "R2 mask unchanged by zero set and direct write");

        // R4 write of zero to that bit does not clear it
        wr(12'h100, 32'hFFFF_EFFF);
        idle();
        rd_chk(12'h100, 32'h0000_1000, 1'b1, "R4 sticky against other-bit clear");

        // R4 W1C clears; R6 output falls
        wr(12'h100, 32'h0000_1000);
        idle();
        rd_chk(12'h100, 32'h0, 1'b0, "R4 W1C clears, R6 irq low");

        // R3 INTx level follows and is not cleared by a status write
        intx_lvl = 4'b0100;
        idle(); idle();
        rd_chk(12'h100, 32'h0000_0004, 1'b0, "R3 INTC level seen");
        wr(12'h100, 32'hFFFF_FFFF);
        idle();
        rd_chk(12'h100, 32'h0000_0004, 1'b0, "R3 level survives W1C");
        wr(12'h10C, 32'h0000_0004);
        idle();
        rd_chk(12'h100, 32'h0000_0004, 1'b1, "R3 unmasked INTx drives R6 irq");
        intx_lvl = 4'b0000;
        idle(); idle();
        rd_chk(12'h100, 32'h0, 1'b0, "R3 level drop clears bit");

        // R5 event and clear on bit 23 (evt_in[19]) together
        pulse(28'h1 << 19);
        bus_wr_en = 1'b1; bus_addr = 12'h100; bus_wdata = 32'h0080_0000;
        evt_in = 28'h1 << 19;
        @(posedge clk); #1;
        bus_wr_en = 1'b0; bus_wdata = '0; evt_in = '0;
        idle();
        rd_chk(12'h100, 32'h0080_0000, 1'b0, "R5 event wins over clear");
        wr(12'h100, 32'h0080_0000);
        idle();
        rd_chk(12'h100, 32'h0, 1'b0, "R5 later clear succeeds");

        // R6 OR of several sources: unmask tunnel error (bit 31) and bit 14
        wr(12'h10C, 32'h8000_4000);
        pulse((28'h1 << 27) | (28'h1 << 10) | (28'h1 << 0));
        idle();
        rd_chk(12'h100, 32'h8000_4010, 1'b1, "R6 multi-source irq");
        wr(12'h100, 32'h8000_0000);
        idle();
        rd_chk(12'h100, 32'h0000_4010, 1'b1, "R6 irq held by remaining bit");

        // R8 write-only and unused offsets read zero; no strobe reads zero
        rd_chk(12'h108, 32'h0, 1'b1, "R8 mask-set reads zero");
        rd_chk(12'h10C, 32'h0, 1'b1, "R8 mask-clear reads zero");
        rd_chk(12'h200, 32'h0, 1'b1, "R8 unused offset reads zero");
        bus_addr = 12'h100;
        begin
            item_t it;
            it.exp_rd = 32'h0; it.exp_irq = 1'b1; it.tag = "R8 no read strobe";
            sb_q.push_back(it);
        end
        idle();

        // R7 software init sequence
        wr(12'h108, 32'hFFFF_FFFF);
        wr(12'h100, 32'hFFFF_FFFF);
        idle();
        rd_chk(12'h100, 32'h0, 1'b0, "R7 nothing pending after init");
        rd_chk(12'h104, 32'hFFFF_FFFF, 1'b0, "R7 all masked after init");

        idle(); idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule